// File: doc/BRIEF.md
# Audio Transmit Sample Queue with Width Packing

This block sits between a register-write port and the frame-slot transmitter of a serial audio link controller. Software writes 32-bit data words. The block turns each word into one or two 20-bit samples and stores them in a circular queue. Each sample is left-aligned in its container. How a word is split depends on the programmed sample width and on a compact-packing mode. In compact mode one word carries two 16-bit halves.

The transmitter side reads stereo pairs over a ready/valid handshake. The first sample of a pair is the left channel and the second is the right. A drain burst may start only when the queue is at least half full and transmit is enabled with an audio slot selected. The burst then keeps releasing pairs for as long as the consumer accepts them.

Four status flags follow the fill level: empty, half-empty, full and underrun. The block updates them on each data write and on each pair it sends.

Top module: `aud_txq_top`

## Requirements
- R1: The control word has the following fields. Bit 0 is transmit enable. Bits [2:1] select slot 3 and slot 4. Bits [4:3] give the sample width: 0 means 16 bits, 1 means 18, 2 means 20 and 3 means 12. Bit 5 requests compact packing. In non-compact mode each data write stores one sample, `(word << s) & 0xFFFFF`, where s is 4, 2, 0 or 8 for widths 16, 18, 20 and 12.
- R2: In compact mode each data write stores two samples. Bits [15:0] are stored first and bits [31:16] second. Each half is shifted left by 8 for the 12-bit width and by 4 otherwise, then masked to 20 bits.
- R3: A compact request with the 18-bit or 20-bit width is ignored, and writes store a single sample as in R1.
- R4: A non-compact write made while the fill level equals the depth is dropped, and the level does not change.
- R5: A compact write is accepted only when level+2 is below the depth. Otherwise the whole word is dropped.
- R6: `pair_valid` rises only when enable is set, at least one slot bit is set and the fill level is at least half the depth.
- R7: Pairs leave in write order, with the older sample on `pair_left`. A burst keeps going while `pair_ready` is high, even below half the depth, and ends at the first cycle with valid high and ready low.
- R8: A data write updates the flags using the resulting level. A non-zero level clears empty and underrun, a level of at least half the depth clears half-empty, and a level equal to the depth sets full.
- R9: A sent pair clears full. If the resulting level is at most half the depth, half-empty is set. If it is zero, empty and underrun are both set.
- R10: After reset the level is 0, empty and half-empty are 1, full and underrun are 0, and no pair is offered.
- R11: `fill_level` gives the exact number of stored samples one cycle after each write or pair transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 6 | Control word (fields in R1) |
| dat_we | input | 1 | Data word write strobe |
| dat_wdata | input | 32 | Data word |
| pair_ready | input | 1 | Transmitter accepts a pair |
| pair_valid | output | 1 | A stereo pair is offered |
| pair_left | output | 20 | Left sample of the offered pair |
| pair_right | output | 20 | Right sample of the offered pair |
| fill_level | output | $clog2(DEPTH)+1 | Stored sample count |
| st_empty | output | 1 | Empty flag |
| st_half_empty | output | 1 | Half-empty flag |
| st_full | output | 1 | Full flag |
| st_underrun | output | 1 | Underrun flag |

## Verification
The hardest state to reach is a burst that has fallen below the half-depth mark and then meets a refusal. After that refusal the queue must hold its pairs even while the consumer is ready again. To get there, the bench fills the queue to exactly half with the consumer stalled. It then raises ready for a single cycle so that one pair leaves, and drops ready for one cycle so that the burst ends. With ready held high afterwards, the bench watches the level stay put until further writes cross the threshold again. The compact-drop boundaries at depth-2 and depth-1 are reached by mixing compact and single-sample writes with the consumer stalled.

// File: rtl/aud_txq_pkg.sv
package aud_txq_pkg;

  localparam int SMP_W  = 20;
  localparam int CFG_W  = 6;
  localparam int CF_EN  = 0;
  localparam int CF_SL  = 1;
  localparam int CF_SZ  = 3;
  localparam int CF_CP  = 5;

  typedef logic [SMP_W-1:0] smp_t;

  typedef enum logic [1:0] {
    SZ_16 = 2'd0,
    SZ_18 = 2'd1,
    SZ_20 = 2'd2,
    SZ_12 = 2'd3
  } smp_size_e;

  typedef struct packed {
    logic      en;
    logic [1:0] slots;
    smp_size_e size;
    logic      compact;
  } tx_cfg_t;

endpackage

// File: rtl/aud_txq_ctl.sv
module aud_txq_ctl
  import aud_txq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output tx_cfg_t          cfg
);

  tx_cfg_t cfg_q, cfg_d;
  smp_size_e sz_in;

  always_comb begin
    sz_in = smp_size_e'(cfg_wdata[CF_SZ +: 2]);
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d.en      = cfg_wdata[CF_EN];
      cfg_d.slots   = cfg_wdata[CF_SL +: 2];
      cfg_d.size    = sz_in;
      // compact packing only exists for the narrow widths
      cfg_d.compact = cfg_wdata[CF_CP] & ((sz_in == SZ_16) | (sz_in == SZ_12));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{en: 1'b0, slots: 2'b00, size: SZ_16, compact: 1'b0};
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/aud_txq_pack.sv
module aud_txq_pack
  import aud_txq_pkg::*;
(
  input  tx_cfg_t     cfg,
  input  logic [31:0] wdata,
  output smp_t        smp0,
  output smp_t        smp1,
  output logic        two
);

  smp_t lane [2];
  smp_t single;

  // one packer lane per 16-bit half of the word
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [15:0] half;
    assign half = wdata[16*g +: 16];
    always_comb begin
      if (cfg.size == SZ_12) lane[g] = {half[11:0], 8'h00};
      else                   lane[g] = {half, 4'h0};
    end
  end

  always_comb begin
    unique case (cfg.size)
      SZ_16:   single = {wdata[15:0], 4'h0};
      SZ_18:   single = {wdata[17:0], 2'b00};
      SZ_20:   single = wdata[19:0];
      SZ_12:   single = {wdata[11:0], 8'h00};
      default: single = '0;
    endcase
  end

  assign two  = cfg.compact;
  assign smp0 = cfg.compact ? lane[0] : single;
  assign smp1 = lane[1];

  always_comb begin
    a_two_narrow_r3: assert (!two || cfg.size == SZ_16 || cfg.size == SZ_12)
      else $error("two-sample packing with a wide sample size");
  end

endmodule

// File: rtl/aud_txq_store.sv
module aud_txq_store
  import aud_txq_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             push_two,
  input  smp_t             push_d0,
  input  smp_t             push_d1,
  input  logic             pop_en,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] level_nxt,
  output smp_t             rd_d0,
  output smp_t             rd_d1
);

  localparam logic [LVL_W:0] DEPTH_X = (LVL_W+1)'(DEPTH);

  smp_t             mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [LVL_W:0]   lvl_p1, lvl_p2;
  logic             acc;
  logic [LVL_W-1:0] add_n;

  always_comb begin
    lvl_p1 = {1'b0, lvl_q} + (LVL_W+1)'(1);
    lvl_p2 = {1'b0, lvl_q} + (LVL_W+1)'(2);
    // acceptance uses the level before any pair leaving this cycle
    acc    = push_req & (push_two ? (lvl_p2 < DEPTH_X) : (lvl_p1 <= DEPTH_X));
    add_n  = acc ? (push_two ? LVL_W'(2) : LVL_W'(1)) : '0;
    lvl_d  = lvl_q + add_n - (pop_en ? LVL_W'(2) : '0);
    wr_d   = wr_q + (acc ? PTR_W'(add_n) : '0);
    rd_d   = rd_q + (pop_en ? PTR_W'(2) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      mem[wr_q] <= push_d0;
      if (push_two) mem[wr_q + PTR_W'(1)] <= push_d1;
    end
  end

  assign rd_d0     = mem[rd_q];
  assign rd_d1     = mem[rd_q + PTR_W'(1)];
  assign level     = lvl_q;
  assign level_nxt = lvl_d;

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, lvl_q} <= DEPTH_X))
    else $error("fill level above depth");

  p_pop_has_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (lvl_q >= LVL_W'(2)))
    else $error("pair popped with fewer than two samples");

  p_compact_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && push_two && !pop_en && (lvl_p2 >= DEPTH_X)) |=> $stable(lvl_q))
    else $error("compact word stored without room");

endmodule

// File: rtl/aud_txq_drain.sv
module aud_txq_drain #(
  parameter  int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH) + 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [1:0]       slots,
  input  logic [LVL_W-1:0] level,
  input  logic             ready,
  output logic             valid,
  output logic             pop
);

  localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);

  logic gate;
  logic burst_q, burst_d;

  always_comb begin
    gate    = tx_en & (|slots);
    valid   = gate & (level >= LVL_W'(2)) & (burst_q | (level >= HALF));
    pop     = valid & ready;
    // a burst survives only while every offered pair is taken
    burst_d = pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_q <= 1'b0;
    else        burst_q <= burst_d;
  end

  p_start_at_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> (level >= HALF))
    else $error("burst started below half depth");

  p_refusal_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (!valid || level >= HALF))
    else $error("burst continued after refusal");

endmodule

// File: rtl/aud_txq_flags.sv
module aud_txq_flags #(
  parameter  int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH) + 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_evt,
  input  logic             pop_evt,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] level_nxt,
  output logic             empty,
  output logic             half_empty,
  output logic             full,
  output logic             underrun
);

  localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic e_q, h_q, f_q, u_q;
  logic e_d, h_d, f_d, u_d;

  always_comb begin
    e_d = e_q; h_d = h_q; f_d = f_q; u_d = u_q;
    if (wr_evt) begin
      if (level_nxt != '0) begin
        e_d = 1'b0;
        u_d = 1'b0;
      end
      if (level_nxt >= HALF) h_d = 1'b0;
      if (level_nxt >= FULL) f_d = 1'b1;
    end
    // pair rules come last and win on a shared cycle
    if (pop_evt) begin
      f_d = 1'b0;
      if (level_nxt <= HALF) h_d = 1'b1;
      if (level_nxt == '0) begin
        e_d = 1'b1;
        u_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q <= 1'b1;
      h_q <= 1'b1;
      f_q <= 1'b0;
      u_q <= 1'b0;
    end else if (wr_evt | pop_evt) begin
      e_q <= e_d;
      h_q <= h_d;
      f_q <= f_d;
      u_q <= u_d;
    end
  end

  assign empty      = e_q;
  assign half_empty = h_q;
  assign full       = f_q;
  assign underrun   = u_q;

  p_empty_is_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    e_q |-> (level == '0))
    else $error("empty flag with stored samples");

  p_full_is_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    f_q |-> (level == FULL))
    else $error("full flag below depth");

  p_underrun_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    u_q |-> e_q)
    else $error("underrun without empty");

endmodule

// File: rtl/aud_txq_top.sv
module aud_txq_top
  import aud_txq_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH) + 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [5:0]       cfg_wdata,
  input  logic             dat_we,
  input  logic [31:0]      dat_wdata,
  input  logic             pair_ready,
  output logic             pair_valid,
  output logic [19:0]      pair_left,
  output logic [19:0]      pair_right,
  output logic [LVL_W-1:0] fill_level,
  output logic             st_empty,
  output logic             st_half_empty,
  output logic             st_full,
  output logic             st_underrun
);

  if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
    $error("DEPTH must be a power of two of at least 8");
  end

  tx_cfg_t          cfg;
  smp_t             smp0, smp1, rd0, rd1;
  logic             two, pop;
  logic [LVL_W-1:0] lvl, lvl_nxt;

  aud_txq_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg       (cfg)
  );

  aud_txq_pack u_pack (
    .cfg   (cfg),
    .wdata (dat_wdata),
    .smp0  (smp0),
    .smp1  (smp1),
    .two   (two)
  );

  aud_txq_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (dat_we),
    .push_two  (two),
    .push_d0   (smp0),
    .push_d1   (smp1),
    .pop_en    (pop),
    .level     (lvl),
    .level_nxt (lvl_nxt),
    .rd_d0     (rd0),
    .rd_d1     (rd1)
  );

  aud_txq_drain #(.DEPTH(DEPTH)) u_drain (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_en (cfg.en),
    .slots (cfg.slots),
    .level (lvl),
    .ready (pair_ready),
    .valid (pair_valid),
    .pop   (pop)
  );

  aud_txq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_evt     (dat_we),
    .pop_evt    (pop),
    .level      (lvl),
    .level_nxt  (lvl_nxt),
    .empty      (st_empty),
    .half_empty (st_half_empty),
    .full       (st_full),
    .underrun   (st_underrun)
  );

  assign pair_left  = rd0;
  assign pair_right = rd1;
  assign fill_level = lvl;

endmodule

// File: tb/aud_txq_top_tb.sv
`timescale 1ns/1ps
module aud_txq_top_tb;

  localparam int DEPTH = 8;
  localparam int LVL_W = $clog2(DEPTH) + 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [5:0]       cfg_wdata;
  logic             dat_we;
  logic [31:0]      dat_wdata;
  logic             pair_ready;
  logic             pair_valid;
  logic [19:0]      pair_left, pair_right;
  logic [LVL_W-1:0] fill_level;
  logic             st_empty, st_half_empty, st_full, st_underrun;

  int checks = 0;
  int errors = 0;
  int mdl_lvl = 0;
  bit done = 0;
  bit [1:0] md_sz = 0;
  bit md_cp = 0;
  logic [19:0] exp_q[$];

  always #2.5 clk = ~clk;

  aud_txq_top #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .pair_ready(pair_ready),
    .pair_valid(pair_valid), .pair_left(pair_left), .pair_right(pair_right),
    .fill_level(fill_level), .st_empty(st_empty), .st_half_empty(st_half_empty),
    .st_full(st_full), .st_underrun(st_underrun)
  );

  task automatic chk(string req, string what, longint got, longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [19:0] single_smp(logic [31:0] v, bit [1:0] sz);
    logic [31:0] t;
    case (sz)
      2'd0: t = v << 4;
      2'd1: t = v << 2;
      2'd2: t = v;
      default: t = v << 8;
    endcase
    return t[19:0];
  endfunction

  function automatic logic [19:0] half_smp(logic [15:0] h, bit [1:0] sz);
    logic [31:0] t;
    t = (sz == 2'd3) ? ({16'h0, h} << 8) : ({16'h0, h} << 4);
    return t[19:0];
  endfunction

  task automatic set_ctl(bit en, bit [1:0] sl, bit [1:0] sz, bit cp);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {cp, sz, sl, en};
    @(negedge clk);
    cfg_we = 1'b0;
    md_sz = sz;
    md_cp = cp && (sz == 2'd0 || sz == 2'd3);
  endtask

  // driver: predicts acceptance and queues expected samples
  task automatic push_word(logic [31:0] v);
    @(negedge clk);
    dat_we = 1'b1;
    dat_wdata = v;
    if (md_cp) begin
      if (mdl_lvl + 2 < DEPTH) begin
        exp_q.push_back(half_smp(v[15:0], md_sz));
        exp_q.push_back(half_smp(v[31:16], md_sz));
        mdl_lvl += 2;
      end
    end else if (mdl_lvl < DEPTH) begin
      exp_q.push_back(single_smp(v, md_sz));
      mdl_lvl += 1;
    end
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic drain(int cyc);
    @(negedge clk);
    pair_ready = 1'b1;
    repeat (cyc) @(negedge clk);
    pair_ready = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compares each transferred pair against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && pair_valid && pair_ready) begin
      if (exp_q.size() < 2) begin
        checks++; errors++;
        $display("FAIL R7 unexpected pair: got %0h/%0h expected nothing", pair_left, pair_right);
      end else begin
        chk("R7", "left sample", pair_left, exp_q.pop_front());
        chk("R7", "right sample", pair_right, exp_q.pop_front());
        mdl_lvl -= 2;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_wdata = '0; dat_we = 0; dat_wdata = '0; pair_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "level", fill_level, 0);
    chk("R10", "empty", st_empty, 1);
    chk("R10", "half", st_half_empty, 1);
    chk("R10", "full", st_full, 0);
    chk("R10", "underrun", st_underrun, 0);
    chk("R10", "valid", pair_valid, 0);

    // R1 16-bit, R6 threshold, R8 flags, R4 drop
    set_ctl(1, 2'b01, 2'd0, 0);
    push_word(32'h0000_1234);
    push_word(32'h000A_BCDE);
    push_word(32'h0000_FFFF);
    chk("R11", "level after three", fill_level, 3);
    chk("R6", "no valid below half", pair_valid, 0);
    chk("R8", "empty cleared", st_empty, 0);
    chk("R8", "half still set", st_half_empty, 1);
    push_word(32'h0000_0005);
    chk("R8", "half cleared", st_half_empty, 0);
    chk("R6", "valid at half", pair_valid, 1);
    chk("R1", "left 16-bit", pair_left, 20'h12340);
    chk("R1", "right 16-bit masked", pair_right, 20'hBCDE0);
    push_word(32'h1111); push_word(32'h2222); push_word(32'h3333); push_word(32'h4444);
    chk("R8", "full set", st_full, 1);
    push_word(32'h7777);
    chk("R4", "level held at depth", fill_level, DEPTH);
    chk("R4", "still full", st_full, 1);
    drain(12);
    chk("R9", "level zero", fill_level, 0);
    chk("R9", "empty", st_empty, 1);
    chk("R9", "underrun", st_underrun, 1);
    chk("R9", "half", st_half_empty, 1);
    chk("R9", "full cleared", st_full, 0);

    // R7 refusal ends the burst below half
    push_word(32'h0A01); push_word(32'h0A02); push_word(32'h0A03); push_word(32'h0A04);
    pair_ready = 1'b1;
    @(negedge clk);
    pair_ready = 1'b0;
    chk("R7", "one pair left", fill_level, 2);
    chk("R9", "half set at two", st_half_empty, 1);
    @(negedge clk);
    pair_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7", "no restart below half", pair_valid, 0);
    chk("R7", "level kept", fill_level, 2);
    push_word(32'h0A05);
    push_word(32'h0A06);
    repeat (8) @(negedge clk);
    pair_ready = 1'b0;
    @(negedge clk);
    chk("R7", "burst drained all", fill_level, 0);

    // R6 gating by enable and slots
    set_ctl(0, 2'b01, 2'd0, 0);
    push_word(32'hB1); push_word(32'hB2); push_word(32'hB3); push_word(32'hB4);
    chk("R6", "disabled", pair_valid, 0);
    chk("R8", "underrun cleared", st_underrun, 0);
    set_ctl(1, 2'b00, 2'd0, 0);
    chk("R6", "no slot", pair_valid, 0);
    set_ctl(1, 2'b10, 2'd0, 0);
    chk("R6", "slot four", pair_valid, 1);
    drain(10);

    // R1 other widths
    set_ctl(1, 2'b01, 2'd1, 0);
    push_word(32'h0003_FFFF); push_word(32'h0001_2345);
    set_ctl(1, 2'b01, 2'd2, 0);
    push_word(32'hFFF1_2345); push_word(32'h000A_BCDE);
    drain(10);
    set_ctl(1, 2'b01, 2'd3, 0);
    push_word(32'h0000_0ABC); push_word(32'hFFFF_F123);
    push_word(32'h0); push_word(32'h0000_0800);
    drain(10);

    // R2 compact 16 and 12
    set_ctl(1, 2'b01, 2'd0, 1);
    push_word(32'h89AB_4321);
    chk("R2", "two samples", fill_level, 2);
    set_ctl(1, 2'b01, 2'd3, 1);
    push_word(32'h0FFF_0ABC);
    push_word(32'hF00F_1234);
    drain(12);

    // R3 compact forced off for 18/20
    set_ctl(1, 2'b01, 2'd1, 1);
    push_word(32'h0001_2345);
    chk("R3", "single at 18", fill_level, 1);
    set_ctl(1, 2'b01, 2'd2, 1);
    push_word(32'h0005_4321);
    chk("R3", "single at 20", fill_level, 2);
    push_word(32'h1); push_word(32'h2);
    drain(10);

    // R5 compact acceptance boundary
    set_ctl(1, 2'b01, 2'd0, 1);
    push_word(32'h0002_0001); push_word(32'h0004_0003); push_word(32'h0006_0005);
    chk("R5", "accepted up to six", fill_level, 6);
    push_word(32'h0008_0007);
    chk("R5", "dropped at six", fill_level, 6);
    set_ctl(1, 2'b01, 2'd0, 0);
    push_word(32'h0009);
    set_ctl(1, 2'b01, 2'd0, 1);
    push_word(32'h000B_000A);
    chk("R5", "dropped at seven", fill_level, 7);
    set_ctl(1, 2'b01, 2'd0, 0);
    push_word(32'h000C);
    chk("R8", "full via single", st_full, 1);
    drain(12);

    chk("R7", "scoreboard empty", exp_q.size(), 0);
    chk("R11", "final level", fill_level, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule